// File: doc/BRIEF.md
# PWM Timer with Shadowed Match Registers

This block is a free-running timer whose count advances once every programmable number of clock cycles. A bank of compare registers is checked against the count. A compare hit can set a sticky interrupt flag and can send the count back to zero. Channel 0 marks the end of a period, and channels 1 and up each drive one single-edge PWM output.

In PWM mode, software writes new compare values into shadow copies. The live compare values stay as they are until software marks the channel as released. The copy then happens only when the period wraps, so a period never runs with a mix of old and new settings. With PWM mode off, the block is a plain timer: compare writes take effect at once and the PWM outputs stay low.

Register map (4-bit word address):
- 0, control: bit 0 run, bit 1 hold (count and prescale held at zero), bit 2 PWM mode.
- 1, prescale limit.
- 2, count (read only).
- 3, flags (write one to clear).
- 4, configuration: bits 0..N-1 interrupt enables, bits 8..8+N-1 reset-on-hit enables.
- 5, release (write one to set, reads as pending).
- 8+k, compare register k. It reads back the shadow copy.

Top module: `pwm_shadow_timer`

## Requirements
- R1: After reset, every register reads zero, the count is zero, and irq and all PWM outputs are low.
- R2: While run (control bit 0) is set and hold is clear, the count rises by one each time the prescale counter has reached the prescale limit, which is once every limit+1 clocks. Clearing run freezes the count and restarts the prescale counter from zero.
- R3: While hold (control bit 1) is set, the count and the prescale counter are forced to zero.
- R4: On a count step where the count equals compare value k, flag k (address 3, bit k) is set and stays set. Writing a one to the bit clears it. A new hit in the same cycle as the clear wins.
- R5: irq is high exactly when some flag is set whose enable bit (address 4, bit k) is also set.
- R6: On a count step where the count equals compare value k and reset-on-hit bit k (address 4, bit 8+k) is set, the count goes to zero instead of rising. In PWM mode channel 0 always behaves this way, and such a wrap is the period boundary.
- R7: With PWM mode (control bit 2) clear, a write to compare register k changes both the shadow and the live value at once, and every PWM output is low.
- R8: With PWM mode set, a write to compare register k changes only the shadow. Writing one to release bit k (address 5) marks it pending. At the next period boundary, each pending live value takes its shadow value and all pending bits clear. A release written in that same cycle stays pending.
- R9: In PWM mode, output k-1 is driven by channel k. It goes high at each period boundary and while hold is set, and goes low on the count step that hits compare k. If both happen on the same step, high wins.
- R10: Writes to the count address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data for bus_addr, combinational |
| irq | output | 1 | Enabled-flag interrupt |
| pwm_out | output | N_MATCH-1 (6) | PWM outputs, bit k-1 from channel k |

## Verification
The bench targets three things:
- The period wrap with pending releases. A design that copied shadow values at write time, or at some step other than the wrap, would change the duty cycle in the middle of a period and leave release bits set or cleared at the wrong cycle.
- Compare values at both ends. A compare of zero must drop its output after one step. A compare equal to the period must hold the output high for the whole period, so a design that resolves the set/clear conflict the wrong way would show a one-step notch. A compare above the period must never fire.
- The prescale counter when run or hold changes, and the sticky flags under clear-by-write. A slip there shifts every later count by a cycle, and the per-clock comparison against the model catches it.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
   localparam int ADDR_W      = 4;
   localparam int CTRL_W      = 3;
   localparam int MAX_MATCH   = 8;
   localparam int CFG_RST_LSB = 8;

   localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
   localparam logic [ADDR_W-1:0] A_PRE    = 4'd1;
   localparam logic [ADDR_W-1:0] A_COUNT  = 4'd2;
   localparam logic [ADDR_W-1:0] A_FLAG   = 4'd3;
   localparam logic [ADDR_W-1:0] A_CFG    = 4'd4;
   localparam logic [ADDR_W-1:0] A_REL    = 4'd5;
   localparam logic [ADDR_W-1:0] A_MATCH0 = 4'd8;

   localparam int CB_RUN  = 0;
   localparam int CB_HOLD = 1;
   localparam int CB_PWM  = 2;
endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
   parameter int PRE_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold,
   input  logic [PRE_W-1:0] limit,
   output logic             tick
);
   logic [PRE_W-1:0] div_q;

   // ">=" so that lowering the limit mid-count cannot strand the divider
   assign tick = run && !hold && (div_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_q <= '0;
      else if (!run || hold || tick)
         div_q <= '0;
      else
         div_q <= div_q + 1'b1;
   end
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             tick,
   input  logic             wrap,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (hold)
         count <= '0;
      else if (tick)
         count <= wrap ? '0 : count + 1'b1;
   end
endmodule

// File: rtl/pwmt_match_chan.sv
module pwmt_match_chan #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic             tick,
   input  logic             pwm_mode,
   input  logic             boundary,
   input  logic             released,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   output logic             hit,
   output logic [CNT_W-1:0] shadow
);
   logic [CNT_W-1:0] live_q;

   assign hit = tick && (count == live_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shadow <= '0;
      else if (wr)
         shadow <= wdata;
   end

   // Timer mode: write-through. PWM mode: copy the old shadow at the wrap.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         live_q <= '0;
      else if (!pwm_mode) begin
         if (wr)
            live_q <= wdata;
      end else if (boundary && released)
         live_q <= shadow;
   end
endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer
   import pwmt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int PRE_W   = 32,
   parameter int N_MATCH = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [CNT_W-1:0]   bus_wdata,
   output logic [CNT_W-1:0]   bus_rdata,
   output logic               irq,
   output logic [N_MATCH-2:0] pwm_out
);
   localparam int N_PWM = N_MATCH - 1;

   if (N_MATCH < 2 || N_MATCH > MAX_MATCH) begin : g_bad_nmatch
      $error("N_MATCH must lie in 2..8");
   end
   if (CNT_W < CFG_RST_LSB + MAX_MATCH) begin : g_bad_cntw
      $error("CNT_W must be at least 16");
   end
   if (PRE_W < 1 || PRE_W > CNT_W) begin : g_bad_prew
      $error("PRE_W must lie in 1..CNT_W");
   end

   logic [CTRL_W-1:0]  ctrl_q;
   logic [PRE_W-1:0]   pre_q;
   logic [N_MATCH-1:0] flag_q, ien_q, rsten_q, rel_q;
   logic [N_MATCH-1:0] hit, rst_eff, xfer, wr_match;
   logic [CNT_W-1:0]   shadow_w [N_MATCH];
   logic [CNT_W-1:0]   count_q;
   logic               run, hold, pwm_mode, tick, boundary;
   logic               wr_ctrl, wr_pre, wr_flag, wr_cfg, wr_rel;

   assign run      = ctrl_q[CB_RUN];
   assign hold     = ctrl_q[CB_HOLD];
   assign pwm_mode = ctrl_q[CB_PWM];

   assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
   assign wr_pre  = bus_we && (bus_addr == A_PRE);
   assign wr_flag = bus_we && (bus_addr == A_FLAG);
   assign wr_cfg  = bus_we && (bus_addr == A_CFG);
   assign wr_rel  = bus_we && (bus_addr == A_REL);

   // Channel 0 always wraps the count in PWM mode.
   assign rst_eff  = rsten_q | N_MATCH'(pwm_mode);
   assign boundary = |(hit & rst_eff);
   assign xfer     = (pwm_mode && boundary) ? rel_q : '0;

   pwmt_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .hold(hold),
      .limit(pre_q), .tick(tick)
   );

   pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .hold(hold), .tick(tick),
      .wrap(boundary), .count(count_q)
   );

   for (genvar k = 0; k < N_MATCH; k++) begin : g_ch
      assign wr_match[k] = bus_we && (bus_addr == A_MATCH0 + ADDR_W'(k));

      pwmt_match_chan #(.CNT_W(CNT_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .count(count_q), .tick(tick),
         .pwm_mode(pwm_mode), .boundary(boundary), .released(rel_q[k]),
         .wr(wr_match[k]), .wdata(bus_wdata),
         .hit(hit[k]), .shadow(shadow_w[k])
      );

      if (k > 0) begin : g_pwm
         logic out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               out_q <= 1'b0;
            else if (!pwm_mode)
               out_q <= 1'b0;
            else if (hold || boundary)
               out_q <= 1'b1;
            else if (hit[k])
               out_q <= 1'b0;
         end
         assign pwm_out[k-1] = out_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         pre_q   <= '0;
         ien_q   <= '0;
         rsten_q <= '0;
         flag_q  <= '0;
         rel_q   <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
         if (wr_pre)  pre_q  <= bus_wdata[PRE_W-1:0];
         if (wr_cfg) begin
            ien_q   <= bus_wdata[N_MATCH-1:0];
            rsten_q <= bus_wdata[CFG_RST_LSB +: N_MATCH];
         end
         flag_q <= (flag_q & ~(wr_flag ? bus_wdata[N_MATCH-1:0] : '0)) | hit;
         rel_q  <= (rel_q & ~xfer) | (wr_rel ? bus_wdata[N_MATCH-1:0] : '0);
      end
   end

   assign irq = |(flag_q & ien_q);

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL:  bus_rdata[CTRL_W-1:0]  = ctrl_q;
         A_PRE:   bus_rdata[PRE_W-1:0]   = pre_q;
         A_COUNT: bus_rdata              = count_q;
         A_FLAG:  bus_rdata[N_MATCH-1:0] = flag_q;
         A_CFG: begin
            bus_rdata[N_MATCH-1:0]            = ien_q;
            bus_rdata[CFG_RST_LSB +: N_MATCH] = rsten_q;
         end
         A_REL:   bus_rdata[N_MATCH-1:0] = rel_q;
         default: begin
            for (int k = 0; k < N_MATCH; k++)
               if (bus_addr == A_MATCH0 + ADDR_W'(k))
                  bus_rdata = shadow_w[k];
         end
      endcase
   end
endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker
   import pwmt_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int N_MATCH = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_we,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [CTRL_W-1:0]  ctrl_q,
   input logic [CNT_W-1:0]   count_q,
   input logic [N_MATCH-1:0] flag_q,
   input logic [N_MATCH-1:0] rel_q,
   input logic               boundary,
   input logic [N_MATCH-2:0] pwm_out
);
   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[CB_RUN] && !ctrl_q[CB_HOLD]) |=>
         (count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1) || (count_q == '0));

   a_r2_stopped_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[CB_RUN] && !ctrl_q[CB_HOLD]) |=> $stable(count_q));

   a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[CB_HOLD] |=> (count_q == '0));

   a_r4_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == A_FLAG) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

   a_r7_timer_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[CB_PWM] |=> (pwm_out == '0));

   a_r8_release_drains: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[CB_PWM] && boundary && !(bus_we && bus_addr == A_REL)) |=> (rel_q == '0));
endmodule

bind pwm_shadow_timer pwmt_checker #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .ctrl_q(ctrl_q), .count_q(count_q), .flag_q(flag_q), .rel_q(rel_q),
   .boundary(boundary), .pwm_out(pwm_out)
);

// File: tb/pwm_shadow_timer_tb.sv
module pwm_shadow_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   logic [5:0]  pwm_out;

   int    n_vec = 0;
   int    n_bad = 0;
   int    cyc = 0;
   string cur_req = "R1";

   // Reference model state, already advanced past the most recent posedge
   logic [31:0] m_pc, m_cnt, m_pre;
   logic [31:0] m_act [7];
   logic [31:0] m_sh  [7];
   logic [2:0]  m_ctrl;
   logic [6:0]  m_flag, m_ien, m_rst, m_rel;
   logic [5:0]  m_pwm;

   always #10 clk = ~clk;

   pwm_shadow_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .pwm_out(pwm_out)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   function automatic logic [31:0] exp_read(input logic [3:0] a);
      logic [31:0] r = '0;
      case (a)
         4'd0: r[2:0] = m_ctrl;
         4'd1: r = m_pre;
         4'd2: r = m_cnt;
         4'd3: r[6:0] = m_flag;
         4'd4: begin r[6:0] = m_ien; r[14:8] = m_rst; end
         4'd5: r[6:0] = m_rel;
         default: if (a >= 4'd8 && a <= 4'd14) r = m_sh[a - 4'd8];
      endcase
      return r;
   endfunction

   task automatic model_reset();
      m_pc = '0; m_cnt = '0; m_pre = '0; m_ctrl = '0;
      m_flag = '0; m_ien = '0; m_rst = '0; m_rel = '0; m_pwm = '0;
      for (int k = 0; k < 7; k++) begin m_act[k] = '0; m_sh[k] = '0; end
   endtask

   task automatic model_adv(input logic we, input logic [3:0] a, input logic [31:0] d);
      logic run, hold, pm, tick, bnd;
      logic [6:0] hit, re;
      run  = m_ctrl[0];
      hold = m_ctrl[1];
      pm   = m_ctrl[2];
      tick = run && !hold && (m_pc >= m_pre);
      for (int k = 0; k < 7; k++) hit[k] = tick && (m_cnt == m_act[k]);
      re  = m_rst | {6'b0, pm};
      bnd = |(hit & re);
      for (int k = 1; k < 7; k++) begin
         if (!pm) m_pwm[k-1] = 1'b0;
         else if (hold || bnd) m_pwm[k-1] = 1'b1;
         else if (hit[k]) m_pwm[k-1] = 1'b0;
      end
      for (int k = 0; k < 7; k++)
         if (pm && bnd && m_rel[k]) m_act[k] = m_sh[k];
      if (we && a >= 4'd8 && a <= 4'd14) begin
         m_sh[a - 4'd8] = d;
         if (!pm) m_act[a - 4'd8] = d;
      end
      m_rel  = (m_rel & ~((pm && bnd) ? m_rel : 7'd0)) | ((we && a == 4'd5) ? d[6:0] : 7'd0);
      m_flag = (m_flag & ~((we && a == 4'd3) ? d[6:0] : 7'd0)) | hit;
      if (!run || hold || tick) m_pc = '0; else m_pc = m_pc + 1;
      if (hold) m_cnt = '0;
      else if (tick) m_cnt = bnd ? 32'd0 : m_cnt + 1;
      if (we && a == 4'd0) m_ctrl = d[2:0];
      if (we && a == 4'd1) m_pre = d;
      if (we && a == 4'd4) begin m_ien = d[6:0]; m_rst = d[14:8]; end
   endtask

   task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", cur_req, what, got, exp);
      end
   endtask

   task automatic step(input logic we, input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      check("rdata", bus_rdata, exp_read(bus_addr));
      check("pwm_out", {26'd0, pwm_out}, {26'd0, m_pwm});
      check("irq", {31'd0, irq}, {31'd0, |(m_flag & m_ien)});
      bus_we = we; bus_addr = a; bus_wdata = d;
      model_adv(we, a, d);
   endtask

   task automatic idle(input int n, input logic [3:0] a);
      for (int i = 0; i < n; i++) step(1'b0, a, 32'd0);
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_adv(1'b0, 4'd0, 32'd0);

      // R1: every register reads zero after reset
      cur_req = "R1";
      for (int a = 0; a < 16; a++) idle(1, 4'(a));
      idle(1, 4'd0);

      // R7: timer mode, compare writes take effect at once
      cur_req = "R7";
      step(1'b1, 4'd8, 32'd20);
      step(1'b1, 4'd9, 32'd5);
      step(1'b1, 4'd10, 32'd9);
      step(1'b1, 4'd4, 32'h0000_007F);
      step(1'b1, 4'd1, 32'd2);
      idle(1, 4'd9);
      // R2: running with prescale limit 2
      cur_req = "R2";
      step(1'b1, 4'd0, 32'd1);
      idle(40, 4'd2);
      // R10: count is read only
      cur_req = "R10";
      step(1'b1, 4'd2, 32'h0000_1234);
      idle(3, 4'd2);
      // R4 and R5: sticky flags, write-one clear, irq follows
      cur_req = "R4";
      idle(3, 4'd3);
      step(1'b1, 4'd3, 32'h0000_0002);
      idle(2, 4'd3);
      cur_req = "R5";
      step(1'b1, 4'd4, 32'h0000_0004);
      idle(2, 4'd3);
      step(1'b1, 4'd3, 32'h0000_007F);
      idle(2, 4'd3);
      // R2: stop freezes, restart
      cur_req = "R2";
      step(1'b1, 4'd0, 32'd0);
      idle(10, 4'd2);
      step(1'b1, 4'd0, 32'd1);
      idle(5, 4'd2);
      // R3: hold forces zero
      cur_req = "R3";
      step(1'b1, 4'd0, 32'd3);
      idle(5, 4'd2);
      step(1'b1, 4'd0, 32'd1);
      // R6: reset on channel 2 hit (compare 9)
      cur_req = "R6";
      step(1'b1, 4'd4, 32'h0000_047F);
      idle(80, 4'd2);

      // R9: PWM mode, period 10, edge values 0, 9 and above period
      cur_req = "R9";
      step(1'b1, 4'd0, 32'd3);
      step(1'b1, 4'd4, 32'h0000_007F);
      step(1'b1, 4'd1, 32'd0);
      step(1'b1, 4'd8, 32'd9);
      step(1'b1, 4'd9, 32'd3);
      step(1'b1, 4'd10, 32'd0);
      step(1'b1, 4'd11, 32'd9);
      step(1'b1, 4'd12, 32'd12);
      step(1'b1, 4'd13, 32'd5);
      step(1'b1, 4'd14, 32'd7);
      step(1'b1, 4'd0, 32'd7);
      idle(3, 4'd2);
      step(1'b1, 4'd0, 32'd5);
      idle(35, 4'd3);

      // R8: shadow writes wait for release and the period wrap
      cur_req = "R8";
      step(1'b1, 4'd9, 32'd6);
      step(1'b1, 4'd8, 32'd5);
      idle(25, 4'd9);
      step(1'b1, 4'd5, 32'h0000_0003);
      idle(25, 4'd5);
      step(1'b1, 4'd13, 32'd1);
      step(1'b1, 4'd5, 32'h0000_0020);
      idle(20, 4'd5);

      // R4: clears racing against hits
      cur_req = "R4";
      for (int i = 0; i < 12; i++) begin
         step(1'b1, 4'd3, 32'h0000_007F);
         idle(2, 4'd3);
      end

      // R7: leaving PWM mode drives outputs low
      cur_req = "R7";
      step(1'b1, 4'd0, 32'd1);
      idle(6, 4'd2);
      step(1'b1, 4'd12, 32'd2);
      idle(6, 4'd3);

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule